// File: doc/BRIEF.md
# Dual Down-Counter Timer with Interrupt Flags

This block is a byte-wide register file for a host bus. It holds two 16-bit down-counters, a 16-bit reload value for the first counter, and a pair of 7-bit registers: one of pending interrupt flags and one of enables. The host picks one of sixteen byte registers with a 4-bit index taken from address bits [12:9]. It reads the running counts on the fly and writes either byte of a counter without disturbing the other byte's live value.

Both counters step down once per prescaler period, a parameter number of clocks. In continuous mode, the first counter reloads itself from its reload register each time it passes zero and raises flag bit 6. Outside that mode, the counter rolls over to 0xFFFF and raises no flag. An outside shift-complete pulse raises flag bit 2. The single interrupt line follows that flag gated by its enable. The remaining indices are plain byte storage. One of them, the auxiliary control byte, supplies the mode field.

Top module: `vtiu_timer_irq_unit`

## Requirements
- R1: The register is selected by the 4-bit index on address bits [12:9]. Index 4/5 reads counter A low/high, 6/7 read and write the reload value low/high, 8/9 read counter B low/high, 13 reads the flags as {0, flags[6:0]}, and 14 reads the enables as {0, enables[6:0]}.
- R2: While reset is held and after it is released, both counters and the reload value read 0xFFFF, flags and enables read 0x00, and the interrupt output is low.
- R3: A write to a counter's low (high) byte loads that byte and keeps the other byte of the count as it was in that cycle. Counting continues from the merged value in the next period.
- R4: Each counter decrements by one once every PRESCALE clocks. Counter B rolls over from 0x0000 to 0xFFFF.
- R5: A read of index 4 or 5 clears flag bit 6.
- R6: When auxiliary byte (index 11) bits [7:6] equal 01, counter A passing zero loads the reload value and sets flag bit 6.
- R7: With any other value in auxiliary bits [7:6], counter A rolls over from 0x0000 to 0xFFFF and flag bit 6 stays clear.
- R8: A write to index 13 clears each flag whose bit is 1 in the written byte and leaves the others unchanged.
- R9: A write to index 14 with bit 7 set ORs bits [6:0] into the enables. With bit 7 clear, it clears each enable whose bit is 1.
- R10: A pulse on xfer_done_i sets flag bit 2. irq_o is high exactly when flag bit 2 and enable bit 2 are both set, and it changes at the same edge as they do. Flag bit 6 does not drive it.
- R11: Indices 0, 1, 2, 3, 10, 11, 12 and 15 read back the last byte written to them, and reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Host access select |
| bus_rd_i | input | 1 | Read strobe (with select) |
| bus_wr_i | input | 1 | Write strobe (with select) |
| bus_addr_i | input | 4 | Address bits [12:9], the register index |
| bus_wdata_i | input | 8 | Write data |
| xfer_done_i | input | 1 | Shift-complete event pulse, sets flag bit 2 |
| bus_rdata_o | output | 8 | Read data for the selected index, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational, so a read returns the state left by the last edge. Every write, flag change, enable change and interrupt change lands on the edge that samples the strobe or event, and each is visible one clock later. The bench drives exactly one access per clock and counts edges from each counter load. With the prescaler set to one, it can predict every counter value, the zero crossing and the reload edge to the cycle. A second instance with a divide of three is sampled twice, exactly 30 clocks apart, and must show a drop of exactly ten whatever its prescaler phase.

// File: rtl/vtiu_pkg.sv
package vtiu_pkg;

  typedef enum logic [3:0] {
    RI_PORTB_DATA = 4'd0,
    RI_PORTA_DATA = 4'd1,
    RI_PORTB_DIR  = 4'd2,
    RI_PORTA_DIR  = 4'd3,
    RI_CA_LO      = 4'd4,
    RI_CA_HI      = 4'd5,
    RI_RLD_LO     = 4'd6,
    RI_RLD_HI     = 4'd7,
    RI_CB_LO      = 4'd8,
    RI_CB_HI      = 4'd9,
    RI_SHIFT      = 4'd10,
    RI_AUX        = 4'd11,
    RI_PERIPH     = 4'd12,
    RI_FLAGS      = 4'd13,
    RI_ENABLES    = 4'd14,
    RI_PORTA_RAW  = 4'd15
  } reg_idx_e;

  localparam int FLAG_W     = 7;
  localparam int FLAG_SHIFT = 2;
  localparam int FLAG_CA    = 6;
  localparam logic [1:0] MODE_CONT = 2'b01;

  // Indices that are simple read/write byte storage.
  function automatic logic is_plain(logic [3:0] i);
    case (i)
      RI_PORTB_DATA, RI_PORTA_DATA, RI_PORTB_DIR, RI_PORTA_DIR,
      RI_SHIFT, RI_AUX, RI_PERIPH, RI_PORTA_RAW: is_plain = 1'b1;
      default:                                   is_plain = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vtiu_prescaler.sv
module vtiu_prescaler #(
  parameter int DIV = 6,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    if (tick_o) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (DIV > 1) begin : g_gap_chk
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o) else $error("tick pulses back to back"); // R4
    end
  endgenerate

endmodule

// File: rtl/vtiu_down_counter.sv
module vtiu_down_counter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              cont_i,
  input  logic [CNT_W-1:0]  reload_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign cnt_o   = cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (wr_lo_i) begin
      cnt_d = {cnt_q[CNT_W-1:BYTE_W], wdata_i};
    end else if (wr_hi_i) begin
      cnt_d = {wdata_i, cnt_q[BYTE_W-1:0]};
    end else if (tick_i) begin
      if (at_zero) begin
        wrap_o = 1'b1;
        cnt_d  = cont_i ? reload_i : '1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_lo_i && !wr_hi_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1))
    else $error("count did not step down"); // R4
  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_lo_i && !wr_hi_i && cnt_q == '0 && cont_i) |=> (cnt_q == $past(reload_i)))
    else $error("continuous reload missed"); // R6
  AST_CNT_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_lo_i && !wr_hi_i && cnt_q == '0 && !cont_i) |=> (cnt_q == '1))
    else $error("free rollover missed"); // R7
  AST_LO_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i |=> (cnt_q == {$past(cnt_q[CNT_W-1:BYTE_W]), $past(wdata_i)}))
    else $error("low byte load lost high byte"); // R3
  AST_HI_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_i && !wr_lo_i) |=> (cnt_q == {$past(wdata_i), $past(cnt_q[BYTE_W-1:0])}))
    else $error("high byte load lost low byte"); // R3

endmodule

// File: rtl/vtiu_irq_ctrl.sv
module vtiu_irq_ctrl #(
  parameter int FW      = 7,
  parameter int IRQ_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] set_i,
  input  logic [FW-1:0] clr_i,
  input  logic          en_wr_i,
  input  logic [FW:0]   en_data_i,
  output logic [FW-1:0] flags_o,
  output logic [FW-1:0] en_o,
  output logic          irq_o
);

  logic [FW-1:0] flags_q, flags_d;
  logic [FW-1:0] en_q, en_d;
  logic          irq_q, irq_d;

  always_comb begin
    flags_d = (flags_q & ~clr_i) | set_i;
    en_d    = en_q;
    if (en_wr_i) begin
      if (en_data_i[FW]) en_d = en_q | en_data_i[FW-1:0];
      else               en_d = en_q & ~en_data_i[FW-1:0];
    end
    irq_d = flags_d[IRQ_BIT] & en_d[IRQ_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      en_q    <= en_d;
      irq_q   <= irq_d;
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign irq_o   = irq_q;

  AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_q[IRQ_BIT] && en_q[IRQ_BIT]))
    else $error("irq without flag and enable"); // R10
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)))
    else $error("flag event lost"); // R10
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((flags_q & $past(clr_i & ~set_i)) == '0))
    else $error("flag clear ignored"); // R8
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_i && en_data_i[FW]) |=> ((en_q & $past(en_data_i[FW-1:0])) == $past(en_data_i[FW-1:0])))
    else $error("enable set ignored"); // R9
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_i && !en_data_i[FW]) |=> ((en_q & $past(en_data_i[FW-1:0])) == '0))
    else $error("enable clear ignored"); // R9

endmodule

// File: rtl/vtiu_timer_irq_unit.sv
module vtiu_timer_irq_unit
  import vtiu_pkg::*;
#(
  parameter int PRESCALE = 6,
  parameter int IDX_LSB  = 9,
  localparam int IDX_MSB = IDX_LSB + 3
) (
  input  logic                 clk,
  input  logic                 arst_n,
  input  logic                 bus_sel_i,
  input  logic                 bus_rd_i,
  input  logic                 bus_wr_i,
  input  logic [IDX_MSB:IDX_LSB] bus_addr_i,
  input  logic [7:0]           bus_wdata_i,
  input  logic                 xfer_done_i,
  output logic [7:0]           bus_rdata_o,
  output logic                 irq_o
);

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NREG   = 16;

  // Reset: asserted at once, released on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  // Access decode.
  logic [3:0]      idx;
  logic            wr_en, rd_en;
  logic [NREG-1:0] wr_hit;
  logic            ca_rd;

  assign idx    = bus_addr_i;
  assign wr_en  = bus_sel_i & bus_wr_i;
  assign rd_en  = bus_sel_i & bus_rd_i;
  assign wr_hit = wr_en ? (NREG'(1) << idx) : '0;
  assign ca_rd  = rd_en & ((idx == RI_CA_LO) | (idx == RI_CA_HI));

  // Plain byte storage.
  logic [NREG-1:0][BYTE_W-1:0] plain_rd;

  generate
    for (genvar gi = 0; gi < NREG; gi++) begin : g_plain
      if (is_plain(4'(gi))) begin : g_reg
        logic [BYTE_W-1:0] q, d;
        always_comb d = wr_hit[gi] ? bus_wdata_i : q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= '0;
          else        q <= d;
        end
        assign plain_rd[gi] = q;
      end else begin : g_none
        assign plain_rd[gi] = '0;
      end
    end
  endgenerate

  logic cont_mode;
  assign cont_mode = (plain_rd[RI_AUX][7:6] == MODE_CONT);

  // Reload value for counter A.
  logic [CNT_W-1:0] rld_q, rld_d;

  always_comb begin
    rld_d = rld_q;
    if (wr_hit[RI_RLD_LO]) rld_d[BYTE_W-1:0]     = bus_wdata_i;
    if (wr_hit[RI_RLD_HI]) rld_d[CNT_W-1:BYTE_W] = bus_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rld_q <= '1;
    else        rld_q <= rld_d;
  end

  // Shared step pulse and the two counters.
  logic             tick;
  logic [CNT_W-1:0] ca_cnt, cb_cnt;
  logic             ca_wrap, cb_wrap;

  vtiu_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  vtiu_down_counter #(.BYTE_W(BYTE_W)) u_cnt_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .wr_lo_i  (wr_hit[RI_CA_LO]),
    .wr_hi_i  (wr_hit[RI_CA_HI]),
    .wdata_i  (bus_wdata_i),
    .cont_i   (cont_mode),
    .reload_i (rld_q),
    .cnt_o    (ca_cnt),
    .wrap_o   (ca_wrap)
  );

  vtiu_down_counter #(.BYTE_W(BYTE_W)) u_cnt_b (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .wr_lo_i  (wr_hit[RI_CB_LO]),
    .wr_hi_i  (wr_hit[RI_CB_HI]),
    .wdata_i  (bus_wdata_i),
    .cont_i   (1'b0),
    .reload_i ('1),
    .cnt_o    (cb_cnt),
    .wrap_o   (cb_wrap)
  );

  // Flags and enables.
  logic [FLAG_W-1:0] set_vec, clr_vec, flags, enables;

  always_comb begin
    set_vec             = '0;
    set_vec[FLAG_CA]    = ca_wrap & cont_mode;
    set_vec[FLAG_SHIFT] = xfer_done_i;
    clr_vec             = wr_hit[RI_FLAGS] ? bus_wdata_i[FLAG_W-1:0] : '0;
    if (ca_rd) clr_vec[FLAG_CA] = 1'b1;
  end

  vtiu_irq_ctrl #(.FW(FLAG_W), .IRQ_BIT(FLAG_SHIFT)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_vec),
    .clr_i     (clr_vec),
    .en_wr_i   (wr_hit[RI_ENABLES]),
    .en_data_i (bus_wdata_i),
    .flags_o   (flags),
    .en_o      (enables),
    .irq_o     (irq_o)
  );

  // Read data.
  always_comb begin
    case (idx)
      RI_CA_LO:   bus_rdata_o = ca_cnt[BYTE_W-1:0];
      RI_CA_HI:   bus_rdata_o = ca_cnt[CNT_W-1:BYTE_W];
      RI_RLD_LO:  bus_rdata_o = rld_q[BYTE_W-1:0];
      RI_RLD_HI:  bus_rdata_o = rld_q[CNT_W-1:BYTE_W];
      RI_CB_LO:   bus_rdata_o = cb_cnt[BYTE_W-1:0];
      RI_CB_HI:   bus_rdata_o = cb_cnt[CNT_W-1:BYTE_W];
      RI_FLAGS:   bus_rdata_o = {1'b0, flags};
      RI_ENABLES: bus_rdata_o = {1'b0, enables};
      default:    bus_rdata_o = plain_rd[idx];
    endcase
  end

  AST_CA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_rd && !set_vec[FLAG_CA]) |=> !flags[FLAG_CA])
    else $error("counter read left flag set"); // R5
  AST_CA_FLAG_ONLY_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FLAG_CA]) |-> $past(cont_mode))
    else $error("flag raised outside continuous mode"); // R7
  AST_CB_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
    cb_wrap |=> (cb_cnt == '1))
    else $error("counter B did not roll over"); // R4

endmodule

// File: tb/vtiu_timer_irq_unit_test.sv
module vtiu_timer_irq_unit_test;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       xfer = 1'b0;
  logic [7:0] rdata, rdata2;
  logic       irq, irq2;

  int checks = 0;
  int errors = 0;
  logic chk_valid = 1'b0;

  typedef struct {
    int         kind;   // 0: uut read, 1: uut irq, 2: uut2 read
    string      req;
    logic [7:0] exp;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  vtiu_timer_irq_unit #(.PRESCALE(1)) uut (
    .clk(clk), .arst_n(arst_n), .bus_sel_i(sel), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .xfer_done_i(xfer),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  vtiu_timer_irq_unit #(.PRESCALE(3)) uut2 (
    .clk(clk), .arst_n(arst_n), .bus_sel_i(sel), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .xfer_done_i(xfer),
    .bus_rdata_o(rdata2), .irq_o(irq2)
  );

  // Monitor: pops one expected item per flagged cycle.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (chk_valid) begin
        checks++;
        if (sbq.size() == 0) begin
          errors++;
          $display("FAIL scoreboard empty actual=none expected=item");
        end else begin
          item_t it;
          logic [7:0] act;
          it = sbq.pop_front();
          case (it.kind)
            0:       act = rdata;
            1:       act = {7'b0, irq};
            default: act = rdata2;
          endcase
          if (act !== it.exp) begin
            errors++;
            $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
          end
        end
      end
    end
  end

  task automatic release_bus();
    @(posedge clk);
    #1;
    sel = 1'b0; rd = 1'b0; wr = 1'b0; xfer = 1'b0; chk_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] i, input logic [7:0] e, input string r);
    @(negedge clk);
    sel = 1'b1; rd = 1'b1; addr = i;
    sbq.push_back('{0, r, e});
    chk_valid = 1'b1;
    release_bus();
  endtask

  task automatic rd2_chk(input logic [3:0] i, input logic [7:0] e, input string r);
    @(negedge clk);
    sel = 1'b1; rd = 1'b1; addr = i;
    sbq.push_back('{2, r, e});
    chk_valid = 1'b1;
    release_bus();
  endtask

  task automatic rd2_sample(input logic [3:0] i, output logic [7:0] v);
    @(negedge clk);
    sel = 1'b1; rd = 1'b1; addr = i;
    #2 v = rdata2;
    release_bus();
  endtask

  task automatic irq_chk(input logic e, input string r);
    @(negedge clk);
    sbq.push_back('{1, r, {7'b0, e}});
    chk_valid = 1'b1;
    release_bus();
  endtask

  task automatic wr_reg(input logic [3:0] i, input logic [7:0] v);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = i; wdata = v;
    release_bus();
  endtask

  task automatic idle();
    @(negedge clk);
    release_bus();
  endtask

  task automatic pulse_xfer();
    @(negedge clk);
    xfer = 1'b1;
    release_bus();
  endtask

  initial begin
    logic [7:0] first;
    // R2: values while reset is held.
    rd_chk(4'd4, 8'hFF, "R2");
    rd_chk(4'd5, 8'hFF, "R2");
    rd_chk(4'd6, 8'hFF, "R2");
    rd_chk(4'd7, 8'hFF, "R2");
    rd_chk(4'd8, 8'hFF, "R2");
    rd_chk(4'd9, 8'hFF, "R2");
    rd_chk(4'd13, 8'h00, "R2");
    rd_chk(4'd14, 8'h00, "R2");
    rd_chk(4'd11, 8'h00, "R2");
    irq_chk(1'b0, "R2");
    rd2_chk(4'd9, 8'hFF, "R2");
    @(negedge clk);
    arst_n = 1'b1;
    for (int k = 0; k < 4; k++) idle();
    rd_chk(4'd7, 8'hFF, "R2");
    rd_chk(4'd14, 8'h00, "R2");

    // R11: plain storage.
    wr_reg(4'd15, 8'h5A); rd_chk(4'd15, 8'h5A, "R11");
    wr_reg(4'd12, 8'h3C); rd_chk(4'd12, 8'h3C, "R11");
    wr_reg(4'd0,  8'h81); rd_chk(4'd0,  8'h81, "R11");
    wr_reg(4'd10, 8'hC3); rd_chk(4'd10, 8'hC3, "R11");
    rd_chk(4'd15, 8'h5A, "R11");

    // R1: reload value bytes.
    wr_reg(4'd6, 8'h34); wr_reg(4'd7, 8'h12);
    rd_chk(4'd6, 8'h34, "R1");
    rd_chk(4'd7, 8'h12, "R1");

    // R3/R4: counter B load and step.
    wr_reg(4'd8, 8'h02); wr_reg(4'd9, 8'h01);
    rd_chk(4'd8, 8'h02, "R3");
    rd_chk(4'd9, 8'h01, "R4");
    wr_reg(4'd8, 8'h50); wr_reg(4'd9, 8'h20);
    for (int k = 0; k < 15; k++) idle();
    wr_reg(4'd9, 8'h7A);
    rd_chk(4'd8, 8'h41, "R3");
    wr_reg(4'd8, 8'h09);
    rd_chk(4'd9, 8'h7A, "R3");
    // R4: rollover of counter B.
    wr_reg(4'd8, 8'h01); wr_reg(4'd9, 8'h00);
    rd_chk(4'd9, 8'h00, "R4");
    rd_chk(4'd8, 8'h00, "R4");
    rd_chk(4'd9, 8'hFF, "R4");
    rd_chk(4'd8, 8'hFE, "R4");

    // R9: enable set/clear.
    wr_reg(4'd14, 8'h84); rd_chk(4'd14, 8'h04, "R9");
    wr_reg(4'd14, 8'hC0); rd_chk(4'd14, 8'h44, "R9");
    wr_reg(4'd14, 8'h40); rd_chk(4'd14, 8'h04, "R9");

    // R10: interrupt gating.
    pulse_xfer();
    irq_chk(1'b1, "R10");
    rd_chk(4'd13, 8'h04, "R10");
    wr_reg(4'd14, 8'h04);
    irq_chk(1'b0, "R10");
    rd_chk(4'd13, 8'h04, "R10");
    wr_reg(4'd14, 8'h84);
    irq_chk(1'b1, "R10");
    wr_reg(4'd13, 8'h04);
    irq_chk(1'b0, "R8");
    rd_chk(4'd13, 8'h00, "R8");

    // R6: continuous mode, reload 0x0100, start count 3.
    wr_reg(4'd6, 8'h00); wr_reg(4'd7, 8'h01);
    wr_reg(4'd11, 8'h40);
    wr_reg(4'd4, 8'h03); wr_reg(4'd5, 8'h00);
    rd_chk(4'd13, 8'h00, "R6");
    rd_chk(4'd13, 8'h00, "R6");
    rd_chk(4'd13, 8'h00, "R6");
    rd_chk(4'd13, 8'h00, "R6");
    rd_chk(4'd13, 8'h40, "R6");
    irq_chk(1'b0, "R10");
    pulse_xfer();
    irq_chk(1'b1, "R10");
    wr_reg(4'd13, 8'h04);
    rd_chk(4'd13, 8'h40, "R8");
    rd_chk(4'd4, 8'hFA, "R6");
    rd_chk(4'd13, 8'h00, "R5");
    rd_chk(4'd11, 8'h40, "R11");
    wr_reg(4'd11, 8'h00);

    // R7: free rollover without flag.
    wr_reg(4'd4, 8'h01); wr_reg(4'd5, 8'h00);
    rd_chk(4'd4, 8'h01, "R7");
    rd_chk(4'd4, 8'h00, "R7");
    rd_chk(4'd13, 8'h00, "R7");
    rd_chk(4'd5, 8'hFF, "R7");
    rd_chk(4'd4, 8'hFD, "R7");

    // R4: prescaler divide of 3 over 30 clocks.
    rd2_sample(4'd8, first);
    for (int k = 0; k < 29; k++) idle();
    rd2_chk(4'd8, first - 8'd10, "R4");

    idle();
    idle();
    if (sbq.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sbq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule